// File: doc/BRIEF.md
# Quarter-Step Cascadable Delay Line

This block delays a single-bit signal by a programmable number of clock ticks. Each tick stands for a quarter of one base delay unit. A seven-bit tap code gives weights from a quarter unit (bit 0) up to sixteen units (bit 6). An eighth bit, the chain bit, is captured together with the code by a level-sensitive capture enable. That bit appears on a complementary pair of chain outputs.

Two override inputs force the captured setting. The force-minimum input clears everything, which gives the shortest delay. The force-maximum input loads the largest code pattern and switches in one extra unit, so the delay goes from 31.75 units to exactly 32 units without stepping backwards. An input enable can block the signal before it enters the delay path.

Several stages can be chained without extra gating. The first stage's chain outputs drive its own force-maximum input and the next stage's force-minimum input. One code line is added per stage as that stage's chain bit. A chain gains range but also gains minimum latency.

Top module: `qtap_delay`

## Requirements
- R1: While `cap_en` is high, `code_in` and `casc_in` are captured on every clock. While it is low and no override is active, the captured values hold and changes on the inputs have no effect on the delay.
- R2: Code bit i weighs 2^i quarter ticks. The effective count is E = code plus 4 when the extra unit is active. An input value sampled at clock edge m appears on `sig_out` right after edge m+E+1, so the latency is E+2 cycles.
- R3: `casc_out` equals the captured chain bit and `casc_out_n` is its complement.
- R4: While `force_min` is high, the captured code and chain bit are cleared on each clock and `code_in` is ignored. The latency is then 2 cycles.
- R5: While `force_max` is high (and `force_min` is low), the captured code becomes 1111100 (bits 0 and 1 clear, bits 2 to 6 set) and the extra unit is active. This gives E = 128 and a latency of 130. The chain bit keeps its normal capture behaviour.
- R6: When both overrides are high, `force_min` wins.
- R7: While `in_en` is low, a constant 0 enters the delay path in place of `sig_in`.
- R8: The asynchronous active-low `rst_n` clears the code, the chain bit, the extra unit and the delay path. `sig_out` and `casc_out` are then 0 and `casc_out_n` is 1.
- R9: In a two-stage chain sharing the code bus, the total latency is code+4 with the first chain bit low, and code+132 with it high.
- R10: After an override is released with `cap_en` low, the override's setting stays captured. The extra unit drops out when `force_max` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one quarter unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable, transparent while high |
| code_in | input | CODE_W | Tap code, bit i weighs 2^i quarter ticks |
| casc_in | input | 1 | Chain bit captured with the code |
| force_min | input | 1 | Override to minimum delay |
| force_max | input | 1 | Override to maximum delay plus one unit |
| in_en | input | 1 | Input enable, active high |
| sig_in | input | 1 | Signal to be delayed |
| sig_out | output | 1 | Delayed signal |
| casc_out | output | 1 | Captured chain bit |
| casc_out_n | output | 1 | Complement of the captured chain bit |

## Verification
A wrong captured code or extra-unit flag shows up as an edge on `sig_out` that arrives too early or too late. A single pulse marched through the path exposes the wrong tap exactly E+2 cycles after the input edge, so timing the rising edge of one pulse pins down the effective count. A corrupted chain bit shows on `casc_out` in the cycle after capture. In a chain, it also shifts the total latency by a whole stage's range, 128 ticks.

// File: rtl/qtap_pkg.sv
package qtap_pkg;
  parameter int unsigned QT_CODE_W = 7;
  localparam int unsigned QT_FUNC_W = 16;
  localparam int unsigned QT_UNIT_Q = 4;

  // quarter-tick count for a captured code and the extra-unit flag
  function automatic logic [QT_FUNC_W-1:0] qtap_quarters(input logic [QT_FUNC_W-1:0] code,
                                                         input logic extra);
    return code + (extra ? QT_FUNC_W'(QT_UNIT_Q) : '0);
  endfunction

  // largest code pattern: two lowest bits clear, the rest set
  function automatic logic [QT_FUNC_W-1:0] qtap_max_code(input int unsigned cw);
    return QT_FUNC_W'((1 << cw) - QT_UNIT_Q);
  endfunction
endpackage

// File: rtl/qtap_latch.sv
module qtap_latch
  import qtap_pkg::*;
#(
  parameter int unsigned CODE_W = QT_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [CODE_W-1:0] code_in,
  input  logic              casc_in,
  input  logic              force_min,
  input  logic              force_max,
  output logic [CODE_W-1:0] code_q,
  output logic              casc_q,
  output logic              extra_q
);
  localparam logic [CODE_W-1:0] MAX_PAT = CODE_W'(qtap_max_code(CODE_W));

  // named events for the assertions
  logic min_evt, max_evt, hold_evt;
  assign min_evt  = force_min;
  assign max_evt  = force_max & ~force_min;
  assign hold_evt = ~force_min & ~force_max & ~cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      casc_q  <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      extra_q <= max_evt;
      if (min_evt)      code_q <= '0;
      else if (max_evt) code_q <= MAX_PAT;
      else if (cap_en)  code_q <= code_in;
      if (min_evt)      casc_q <= 1'b0;
      else if (cap_en)  casc_q <= casc_in;
    end
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> ($stable(code_q) && $stable(casc_q) && !extra_q))
    else $error("R1 captured setting moved while closed");

  a_r3_casc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !force_min) |=> (casc_q == $past(casc_in)))
    else $error("R3 chain bit not captured");

  a_r4_min_clear: assert property (@(posedge clk) disable iff (!rst_n)
    force_min |=> (code_q == '0 && !casc_q && !extra_q))
    else $error("R4 minimum override not applied");

  a_r5_max_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (force_max && !force_min) |=> (code_q == MAX_PAT && extra_q))
    else $error("R5 maximum override not applied");

  a_r6_min_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (force_max && force_min) |=> !extra_q)
    else $error("R6 minimum override lost priority");
endmodule

// File: rtl/qtap_shift.sv
module qtap_shift #(
  parameter int unsigned TAPS  = 129,
  parameter int unsigned SEL_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             head,
  output logic             bit_out
);
  logic [TAPS-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_out <= 1'b0;
    end else begin
      sr      <= {sr[TAPS-2:0], bit_in};
      bit_out <= sr[tap_sel];
    end
  end

  assign head = sr[0];
endmodule

// File: rtl/qtap_delay.sv
module qtap_delay
  import qtap_pkg::*;
#(
  parameter int unsigned CODE_W = QT_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [CODE_W-1:0] code_in,
  input  logic              casc_in,
  input  logic              force_min,
  input  logic              force_max,
  input  logic              in_en,
  input  logic              sig_in,
  output logic              sig_out,
  output logic              casc_out,
  output logic              casc_out_n
);
  localparam int unsigned MAX_Q = 1 << CODE_W;
  localparam int unsigned TAPS  = MAX_Q + 1;
  localparam int unsigned SEL_W = $clog2(TAPS);

  logic [CODE_W-1:0] code_q;
  logic              casc_q, extra_q;
  logic [SEL_W-1:0]  tap_sel;
  logic              gated, head;

  qtap_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .code_in(code_in),
    .casc_in(casc_in), .force_min(force_min), .force_max(force_max),
    .code_q(code_q), .casc_q(casc_q), .extra_q(extra_q)
  );

  assign tap_sel = SEL_W'(qtap_quarters(QT_FUNC_W'(code_q), extra_q));
  assign gated   = sig_in & in_en;

  qtap_shift #(.TAPS(TAPS), .SEL_W(SEL_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_in(gated), .tap_sel(tap_sel),
    .head(head), .bit_out(sig_out)
  );

  assign casc_out   = casc_q;
  assign casc_out_n = ~casc_q;

  a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !in_en |=> !head)
    else $error("R7 blocked input reached the path");

  a_r2_zero_tap: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel == '0) |=> (sig_out == $past(head)))
    else $error("R2 zero tap latency wrong");
endmodule

// File: tb/qtap_delay_test.sv
`timescale 1ns/1ps
module qtap_delay_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cap_en, casc_in, force_min, force_max, in_en, sig_in;
  logic [6:0] code_in;
  logic sig_out, casc_out, casc_out_n;

  logic [6:0] ch_code;
  logic ch_d7, ch_le, ch_in;
  logic c0_out, c0_co, c0_con, ch_out, c1_co, c1_con;

  int checks = 0, fails = 0;
  int n = 0;
  bit hist [256];
  logic [6:0] m_code;
  bit m_casc, m_extra, m_out;

  qtap_delay uut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .code_in(code_in),
    .casc_in(casc_in), .force_min(force_min), .force_max(force_max),
    .in_en(in_en), .sig_in(sig_in), .sig_out(sig_out),
    .casc_out(casc_out), .casc_out_n(casc_out_n)
  );

  // two-stage chain: stage 0 drives its own max override and stage 1 min override
  qtap_delay c0 (
    .clk(clk), .rst_n(rst_n), .cap_en(ch_le), .code_in(ch_code),
    .casc_in(ch_d7), .force_min(1'b0), .force_max(c0_co),
    .in_en(1'b1), .sig_in(ch_in), .sig_out(c0_out),
    .casc_out(c0_co), .casc_out_n(c0_con)
  );
  qtap_delay c1 (
    .clk(clk), .rst_n(rst_n), .cap_en(ch_le), .code_in(ch_code),
    .casc_in(1'b0), .force_min(c0_con), .force_max(1'b0),
    .in_en(1'b1), .sig_in(c0_out), .sig_out(ch_out),
    .casc_out(c1_co), .casc_out_n(c1_con)
  );

  function automatic int qeff(input logic [6:0] code, input bit extra);
    int units4 = 0;
    for (int i = 0; i < 7; i++) if (code[i]) units4 += (1 << i);
    if (extra) units4 += 4;
    return units4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: model update from requirements, then compare at the falling edge
  task automatic step(input string tag);
    int e, idx;
    bit g;
    @(posedge clk);
    e = qeff(m_code, m_extra);
    g = sig_in & in_en;
    idx = n - 1 - e;
    m_out = (idx >= 0) ? hist[idx & 255] : 1'b0;
    hist[n & 255] = g;
    n++;
    m_extra = 1'b0;
    if (force_min) begin
      m_code = '0; m_casc = 1'b0;
    end else begin
      if (force_max) begin
        m_code = 7'b1111100; m_extra = 1'b1;
      end else if (cap_en) m_code = code_in;
      if (cap_en) m_casc = casc_in;
    end
    @(negedge clk);
    chk(tag, sig_out, m_out);
    chk("R3", casc_out, m_casc);
    chk("R3", casc_out_n, !m_casc);
  endtask

  // flush with a low input, then time a rising edge through the unit
  task automatic measure(input int exp, input string tag, input bit wiggle);
    int k;
    sig_in = 1'b0;
    for (int i = 0; i < 140; i++) begin
      if (wiggle) code_in = 7'($urandom);
      step(tag);
    end
    sig_in = 1'b1;
    k = 0;
    for (int i = 1; i <= 300; i++) begin
      if (wiggle) code_in = 7'($urandom);
      step(tag);
      if (sig_out) begin k = i; break; end
    end
    chk(tag, k, exp);
    sig_in = 1'b0;
  endtask

  task automatic chain_latency(input logic [6:0] code, input bit d7, input int exp);
    int k;
    ch_code = code; ch_d7 = d7; ch_in = 1'b0; ch_le = 1'b1;
    for (int i = 0; i < 3; i++) step("R2");
    ch_le = 1'b0;
    for (int i = 0; i < 300; i++) step("R2");
    ch_in = 1'b1;
    k = 0;
    for (int i = 1; i <= 400; i++) begin
      step("R2");
      if (ch_out) begin k = i; break; end
    end
    chk("R9", k, exp);
    ch_in = 1'b0;
  endtask

  task automatic idle_inputs();
    cap_en = 1'b0; force_min = 1'b0; force_max = 1'b0;
    in_en = 1'b1; sig_in = 1'b0; casc_in = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1957));
    rst_n = 1'b0;
    idle_inputs();
    code_in = 7'd0;
    ch_code = '0; ch_d7 = 1'b0; ch_le = 1'b0; ch_in = 1'b0;
    m_code = '0; m_casc = 1'b0; m_extra = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", sig_out, 0);
    chk("R8", casc_out, 0);
    chk("R8", casc_out_n, 1);
    rst_n = 1'b1;
    step("R8");

    // R1 capture zero, then close the latch and wiggle the code bus
    cap_en = 1'b1; code_in = 7'd0; step("R1");
    cap_en = 1'b0;
    measure(2, "R1", 1'b1);

    // R2 several codes
    cap_en = 1'b1; code_in = 7'd127; step("R2"); cap_en = 1'b0;
    measure(129, "R2", 1'b0);
    cap_en = 1'b1; code_in = 7'd5; step("R2"); cap_en = 1'b0;
    measure(7, "R2", 1'b0);
    cap_en = 1'b1; code_in = 7'd2; step("R2"); cap_en = 1'b0;
    measure(4, "R2", 1'b0);

    // R3 chain bit capture
    cap_en = 1'b1; casc_in = 1'b1; step("R3");
    chk("R3", casc_out, 1);
    cap_en = 1'b0; casc_in = 1'b0; step("R3");
    chk("R3", casc_out, 1);

    // R5 maximum override with open latch and changing code
    force_max = 1'b1; cap_en = 1'b1;
    measure(130, "R5", 1'b1);
    cap_en = 1'b0; force_max = 1'b0;

    // R4 minimum override ignores the code bus
    force_min = 1'b1; cap_en = 1'b1;
    measure(2, "R4", 1'b1);
    chk("R4", casc_out, 0);

    // R6 both overrides
    force_max = 1'b1;
    measure(2, "R6", 1'b1);
    idle_inputs();

    // R10 override setting held after release
    cap_en = 1'b1; code_in = 7'd40; step("R10"); cap_en = 1'b0;
    force_max = 1'b1; step("R10"); force_max = 1'b0;
    measure(126, "R10", 1'b0);

    // R7 input blocked
    in_en = 1'b0; sig_in = 1'b1;
    for (int i = 0; i < 200; i++) step("R7");
    chk("R7", sig_out, 0);
    idle_inputs();

    // R9 chained stages
    chain_latency(7'd10, 1'b0, 14);
    chain_latency(7'd10, 1'b1, 142);
    chain_latency(7'd0, 1'b0, 4);
    chain_latency(7'd3, 1'b1, 135);

    // R2 random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      cap_en    = ($urandom % 4) == 0;
      code_in   = 7'($urandom);
      casc_in   = 1'($urandom);
      force_min = ($urandom % 32) == 0;
      force_max = ($urandom % 20) == 0;
      in_en     = ($urandom % 10) != 0;
      if (($urandom % 3) == 0) sig_in = ~sig_in;
      step("R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule